// File: doc/BRIEF.md
# Nonzero Difference Index Stack

In a differencing multistage detector stage, only the users whose hard decision changed between two stages contribute to the next correction. This block records them. While the soft decisions stream in, an upstream detector pulses a push strobe for every nonzero entry of the difference vector. Each push carries the 3-bit user index and a sign bit saying whether the difference was positive or negative. The block stores each pair in an eight-deep register file, with a write address that counts up.

During accumulation the consumer pulses the change strobe once per cycle. The block replays the recorded entries newest first, counting its address back down. The replayed index selects a correlation constant and the sign selects add or subtract. A finish flag tells the consumer that the last recorded entry has just been delivered, or that nothing was recorded at all.

All outputs are registered, so they show the result of the inputs sampled at the previous rising edge. Restart returns the address state to zero and leaves the stored words in place.

Top module: `nzd_index_stack`

## Requirements
- R1: After `rst_n` is low, or one cycle after `restart` is high, `wr_en_o`, `rd_en_o`, `finish_o` and `addr_o` are zero. `restart` takes priority over both strobes, and the stack is empty afterwards: a following `pop_i` gives `finish_o`=1 and `rd_en_o`=0.
- R2: With `push_i`=1 and `pop_i`=0 on a stack holding n<8 entries, the next cycle shows `wr_en_o`=1, `rd_en_o`=0 and `addr_o`=n. The word {index, sign} is stored at address n and the count becomes n+1.
- R3: With `pop_i`=1 on a stack holding n≥1 entries, the next cycle shows `rd_en_o`=1, `wr_en_o`=0 and `addr_o`=n-1. `out_idx_o` and `out_sign_o` equal the index and sign pushed at address n-1, and the count becomes n-1. Entries therefore come back newest first.
- R4: `finish_o` is 1 in the cycle after a pop that removes the last entry (n=1, a read still occurs). It is also 1 after a pop on an empty stack, and then `rd_en_o`=0. It is 0 in every other cycle.
- R5: With neither strobe high, the next cycle shows `rd_en_o`=1, `wr_en_o`=0 and `finish_o`=0. `addr_o` is n-1 (0 when empty), and the outputs present the word stored there; the count is unchanged.
- R6: A push on a full stack (8 entries) is ignored and behaves as R5, with `addr_o`=7. Eight following pops return all eight entries in reverse order of pushing.
- R7: When `push_i` and `pop_i` are high together, the pop is performed and the push is discarded: no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return of the address state to empty |
| push_i | input | 1 | Nonzero difference entry present |
| push_idx_i | input | 3 | User index of the entry |
| push_sign_i | input | 1 | Sign of the difference (1 = negative) |
| pop_i | input | 1 | Change strobe: replay one entry |
| wr_en_o | output | 1 | A write took place at `addr_o` |
| rd_en_o | output | 1 | A read took place at `addr_o` |
| addr_o | output | 3 | Register file address of the last access |
| out_idx_o | output | 3 | Replayed user index |
| out_sign_o | output | 1 | Replayed sign |
| finish_o | output | 1 | Recorded entries exhausted |

## Verification
The bench goes after the edges of the count.

- Popping the final entry must read address 0 and raise finish in the same cycle. A design that counts the exit one step late would either drop that read or lose the finish flag.
- Popping an empty stack must raise finish without a read. A wrapping counter would instead read address 7 and continue replaying stale words.
- A ninth push must leave the count at eight. An overflowing design would wrap its count and corrupt address 0 or lose all eight entries.
- With simultaneous push and pop, a design that lets the push win would write a word the consumer never sees.
- Restart must empty the stack, so that a design keeping the count would replay an entry after the restart.

// File: rtl/nzd_stack_pkg.sv
package nzd_stack_pkg;
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_PUSH    = 2'd1,
        OP_POP     = 2'd2,
        OP_RESTART = 2'd3
    } stack_op_e;
endpackage

// File: rtl/nzd_stack_ctrl.sv
module nzd_stack_ctrl
    import nzd_stack_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          push_i,
    input  logic          pop_i,
    output logic          acc_wr,
    output logic          acc_rd,
    output logic [AW-1:0] acc_addr,
    output logic          wr_en_o,
    output logic          rd_en_o,
    output logic          finish_o,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          wr;
        logic          rd;
        logic          fin;
        logic [AW-1:0] addr;
    } ctl_t;

    ctl_t          st_d, st_q;
    stack_op_e     op;
    logic          full;
    logic [CW-1:0] cnt_dec;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign cnt_dec = st_q.cnt - CW'(1);

    always_comb begin
        if (restart)                 op = OP_RESTART;
        else if (pop_i)              op = OP_POP;
        else if (push_i && !full)    op = OP_PUSH;
        else                         op = OP_IDLE;
    end

    always_comb begin
        st_d     = st_q;
        st_d.wr  = 1'b0;
        st_d.rd  = 1'b0;
        st_d.fin = 1'b0;
        unique case (op)
            OP_RESTART: begin
                st_d.cnt  = '0;
                st_d.addr = '0;
            end
            OP_PUSH: begin
                st_d.wr   = 1'b1;
                st_d.addr = st_q.cnt[AW-1:0];
                st_d.cnt  = st_q.cnt + CW'(1);
            end
            OP_POP: begin
                if (st_q.cnt == '0) begin
                    st_d.fin  = 1'b1;
                    st_d.addr = '0;
                end else begin
                    st_d.rd   = 1'b1;
                    st_d.addr = cnt_dec[AW-1:0];
                    st_d.cnt  = cnt_dec;
                    st_d.fin  = (st_q.cnt == CW'(1));
                end
            end
            default: begin
                st_d.rd   = 1'b1;
                st_d.addr = (st_q.cnt == '0) ? '0 : cnt_dec[AW-1:0];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_wr   = st_d.wr;
    assign acc_rd   = st_d.rd;
    assign acc_addr = st_d.addr;
    assign wr_en_o  = st_q.wr;
    assign rd_en_o  = st_q.rd;
    assign finish_o = st_q.fin;
    assign addr_o   = st_q.addr;

    a_r1_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!wr_en_o && !rd_en_o && !finish_o && addr_o == '0 && st_q.cnt == '0));
    a_r2_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !restart && st_q.cnt < CW'(DEPTH)) |=> (st_q.cnt == $past(st_q.cnt) + CW'(1) && wr_en_o));
    a_r3_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !restart && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - CW'(1) && rd_en_o));
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !restart && st_q.cnt == '0) |=> (finish_o && !rd_en_o && !wr_en_o));
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !restart && full) |=> ($stable(st_q.cnt) && !wr_en_o));
    a_r7_pop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |=> !wr_en_o);
    a_r2_access_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_en_o));
    a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/nzd_stack_store.sv
module nzd_stack_store #(
    parameter int DEPTH = 8,
    parameter int EW    = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [EW-1:0] wdata,
    output logic [EW-1:0] rdata_o
);
    logic [EW-1:0] mem_q [DEPTH];
    logic [EW-1:0] rdata_d, rdata_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [EW-1:0] slot_d;
        always_comb begin
            slot_d = mem_q[g];
            if (we && addr == AW'(g)) slot_d = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= slot_d;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = mem_q[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

    a_r3_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));
endmodule

// File: rtl/nzd_index_stack.sv
module nzd_index_stack #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    localparam int AW = $clog2(DEPTH),
    localparam int EW = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             push_i,
    input  logic [IDX_W-1:0] push_idx_i,
    input  logic             push_sign_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic             rd_en_o,
    output logic [AW-1:0]    addr_o,
    output logic [IDX_W-1:0] out_idx_o,
    output logic             out_sign_o,
    output logic             finish_o
);
    logic          acc_wr, acc_rd;
    logic [AW-1:0] acc_addr;
    logic [EW-1:0] rdata;

    nzd_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .acc_wr   (acc_wr),
        .acc_rd   (acc_rd),
        .acc_addr (acc_addr),
        .wr_en_o  (wr_en_o),
        .rd_en_o  (rd_en_o),
        .finish_o (finish_o),
        .addr_o   (addr_o)
    );

    nzd_stack_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (acc_wr),
        .re      (acc_rd),
        .addr    (acc_addr),
        .wdata   ({push_sign_i, push_idx_i}),
        .rdata_o (rdata)
    );

    assign out_sign_o = rdata[EW-1];
    assign out_idx_o  = rdata[IDX_W-1:0];

    a_r4_finish_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |-> !wr_en_o);
endmodule

// File: tb/tb_nzd_index_stack.sv
`timescale 1ns/1ps
module tb_nzd_index_stack;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       push_i = 1'b0;
    logic [2:0] push_idx_i = '0;
    logic       push_sign_i = 1'b0;
    logic       pop_i = 1'b0;
    logic       wr_en_o, rd_en_o, finish_o, out_sign_o;
    logic [2:0] addr_o, out_idx_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    nzd_index_stack dut (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .push_i(push_i), .push_idx_i(push_idx_i), .push_sign_i(push_sign_i),
        .pop_i(pop_i), .wr_en_o(wr_en_o), .rd_en_o(rd_en_o), .addr_o(addr_o),
        .out_idx_o(out_idx_o), .out_sign_o(out_sign_o), .finish_o(finish_o)
    );

    typedef struct packed {
        bit       push;
        bit       pop;
        bit [2:0] idx;
        bit       sg;
        bit       ewr;
        bit       erd;
        bit       efin;
        bit [2:0] eaddr;
        bit [2:0] eidx;
        bit       esg;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 1'b0},
        '{1'b1, 1'b0, 3'd5, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0},
        '{1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, 3'd0, 1'b0},
        '{1'b1, 1'b0, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 3'd0, 1'b0},
        '{1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 3'd7, 1'b0},
        '{1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd2, 3'd7, 1'b0},
        '{1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd2, 1'b1},
        '{1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd5, 1'b0},
        '{1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 3'd5, 1'b0},
        '{1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0},
        '{1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd5, 1'b0},
        '{1'b1, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0},
        '{1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 3'd3, 1'b1}
    };

    task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, sample at the following negedge
    task automatic step(input bit rs, input bit pu, input bit po, input bit [2:0] ix, input bit sg);
        restart = rs; push_i = pu; pop_i = po; push_idx_i = ix; push_sign_i = sg;
        @(negedge clk);
        restart = 1'b0; push_i = 1'b0; pop_i = 1'b0;
    endtask

    task automatic expect_out(input string req, input bit wr, input bit rd, input bit fin,
                              input bit [2:0] ad, input bit [2:0] ix, input bit sg);
        chk(req, {wr_en_o, rd_en_o, finish_o, addr_o}, {wr, rd, fin, ad});
        if (rd) chk(req, {2'b00, out_idx_o, out_sign_o}, {2'b00, ix, sg});
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        string tag;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        expect_out("R1 reset", 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v = TBL[i];
            if (v.push && v.pop)  tag = "R7 push+pop";
            else if (v.efin)      tag = "R4 finish";
            else if (v.pop)       tag = "R3 pop";
            else if (v.push)      tag = "R2 push";
            else                  tag = "R5 idle";
            step(1'b0, v.push, v.pop, v.idx, v.sg);
            expect_out(tag, v.ewr, v.erd, v.efin, v.eaddr, v.eidx, v.esg);
        end

        // R6: fill, overflow push, full drain
        step(1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
        expect_out("R1 restart", 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            step(1'b0, 1'b1, 1'b0, 3'(i), i[0]);
            expect_out("R2 fill", 1'b1, 1'b0, 1'b0, 3'(i), 3'd0, 1'b0);
        end
        step(1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
        expect_out("R6 full push ignored", 1'b0, 1'b1, 1'b0, 3'd7, 3'd7, 1'b1);
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 1'b0, 1'b1, 3'd0, 1'b0);
            expect_out("R6 drain", 1'b0, 1'b1, (k == 7), 3'(7 - k), 3'(7 - k), 1'((7 - k) % 2));
        end
        step(1'b0, 1'b0, 1'b1, 3'd0, 1'b0);
        expect_out("R4 empty pop", 1'b0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0);

        // R1: restart beats a push and empties the stack
        step(1'b0, 1'b1, 1'b0, 3'd4, 1'b1);
        expect_out("R2 push", 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 3'd6, 1'b0);
        expect_out("R1 restart priority", 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 3'd0, 1'b0);
        expect_out("R1 empty after restart", 1'b0, 1'b0, 1'b1, 3'd0, 3'd0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule